// File: doc/BRIEF.md
# SCSI Controller Command Dispatcher

This block is the register front end and command sequencer of a simplified SCSI protocol controller. A host reaches it through a byte-wide register window of sixteen slots. Some slots hold a read-only register on the read side and a separate write-only register on the write side. Command bytes written into the command slot are checked against the controller's connection state. The block can be idle, selecting or connected. A legal command takes effect: it changes the connection state or bus phase, flushes the data FIFO, loads the transfer counter, or latches interrupt causes. An illegal command only latches the illegal-command interrupt cause.

The interrupt causes, the sequence step and the status bits can all be read through the window. The interrupt register is cleared when it is read. A 16-byte data FIFO sits behind one slot, and its fill level appears in the FIFO flags register. There is no back-pressure on the register port. Every access completes in the cycle it is presented. Read data is combinational from `reg_addr`, and the side effects of a read (FIFO pop, interrupt clear) take place at the clock edge that ends the access. A push into a full FIFO and a pop from an empty FIFO are dropped.

Top module: `scsi_cmd_dispatch`

## Requirements
- R1: The slot index is `reg_addr` (byte offset divided by 4). The slots are:
  - Read/write: 0 holds count low, 1 holds count middle, 3 holds the command byte as written, 8 holds config, and 2 is the FIFO data port.
  - Read-only: 4 is status, 5 is interrupt, 6 is sequence step, 7 is FIFO flags.
  - Slots 9 to 15 read 0x00.
  - Writes to slots 4 to 7 (bus ID, timeout, sync period, sync offset) change no readable value.
- R2: Codes 0x00 (no operation), 0x01 (FIFO flush), 0x02 (chip reset) and 0x03 (bus reset) are legal in every state. A flush empties the FIFO.
- R3: Chip reset (0x02) returns the following to their reset values: connection state idle, interrupt 0x00, step 0, phase 000, transfer-complete flag 0, DMA mode 0, transfer counter 0, FIFO empty. The count, command and config registers keep their values.
- R4: Bus reset (0x03) makes the block idle with phase 000. It sets interrupt bit 7 only when config bit 6 is 0.
- R5: Codes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are legal only while connected. Any code outside the three legal groups is never legal. An illegal code sets interrupt bit 6 and changes nothing else.
- R6: Codes 0x40 to 0x47 are legal only while idle. Their effects are:
  - 0x40 and 0x47 set interrupt bit 3.
  - 0x44 and 0x45 have no visible effect.
  - 0x41, 0x42, 0x43 and 0x46 start a selection.
- R7: Bit 7 of the command byte requests DMA, and the legality check uses bits 6:0 only. A legal command copies bit 7 into `dma_mode`. When bit 7 is set, a legal command also loads the 16-bit transfer counter from {count middle, count low}. Status bit 4 is 1 while the transfer counter is zero.
- R8: A selection started at clock edge t connects at edge t+SEL_DELAY. At that edge it sets interrupt bit 3 (function done), sequence step 4 and phase 010 (command). While selecting, groups 0x1x and 0x4x are illegal.
- R9: While connected, the commands act as follows:
  - 0x10 sets interrupt bit 4 and status bit 3, and advances the phase from 010 to 011 and from any other phase to 111.
  - 0x11 sets interrupt bit 3 and phase 111.
  - 0x18 sets interrupt bit 3.
  - 0x12 makes the block idle with phase 000 and sets interrupt bit 5.
- R10: `irq` is 1 whenever any interrupt bit is set. Reading slot 5 returns the current bits, then clears the interrupt register, the sequence step and status bit 3 at that edge. A cause arriving at the same edge is kept.
- R11: The FIFO holds 16 bytes in order. The FIFO flags register is {step[2:0], count[4:0]}. A push when full is dropped, and a read of an empty FIFO returns 0x00.
- R12: The status register is {irq, 0, 0 (parity error), counter zero, transfer complete, phase[2:0]}. Its reset value is 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register slot index |
| reg_wr | input | 1 | Write strobe for the addressed slot |
| reg_rd | input | 1 | Read strobe (applies the read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed slot |
| irq | output | 1 | Interrupt request |
| link_up | output | 1 | Connected to a target as initiator |
| dma_mode | output | 1 | DMA bit of the last legal command |

## Verification
The hardest situation to reach is an interrupt-register read that lands on the same edge where a selection completes. At that edge the old bits must be cleared while function done and step 4 survive. The bench starts a selection and then reads slot 5 on every cycle of the selection window. Because its reference model follows the cycle-exact completion edge, one of those reads meets the completion. The bench also issues commands while the block is selecting, so both command groups are tried against the one state in which neither is legal.

// File: rtl/scsi_disp_pkg.sv
package scsi_disp_pkg;
  typedef enum logic [1:0] {LNK_IDLE = 2'd0, LNK_SEL = 2'd1, LNK_CONN = 2'd2} link_e;
  typedef enum logic [1:0] {GRP_ANY, GRP_CONN, GRP_DISC, GRP_BAD} grp_e;
  typedef enum logic [3:0] {
    ACT_NONE, ACT_FLUSH, ACT_CHIPRST, ACT_BUSRST,
    ACT_XFER, ACT_ICCS, ACT_MSGOK, ACT_FDONE, ACT_SELECT
  } act_e;

  localparam logic [3:0] SLOT_CNT_LO  = 4'd0;
  localparam logic [3:0] SLOT_CNT_MID = 4'd1;
  localparam logic [3:0] SLOT_FIFO    = 4'd2;
  localparam logic [3:0] SLOT_CMD     = 4'd3;
  localparam logic [3:0] SLOT_STAT    = 4'd4;
  localparam logic [3:0] SLOT_INTR    = 4'd5;
  localparam logic [3:0] SLOT_STEP    = 4'd6;
  localparam logic [3:0] SLOT_FFLAG   = 4'd7;
  localparam logic [3:0] SLOT_CFG     = 4'd8;

  localparam int IB_FDONE = 3;
  localparam int IB_BSERV = 4;
  localparam int IB_DISC  = 5;
  localparam int IB_ILL   = 6;
  localparam int IB_BRST  = 7;

  localparam int CFG_RPT_DIS = 6;

  localparam logic [2:0] PH_IDLE = 3'b000;
  localparam logic [2:0] PH_CMD  = 3'b010;
  localparam logic [2:0] PH_STAT = 3'b011;
  localparam logic [2:0] PH_MIN  = 3'b111;

  localparam logic [2:0] STEP_SENT = 3'd4;
endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_disp_pkg::*;
(
  input  logic [7:0] code_i,
  output grp_e       grp_o,
  output act_e       act_o,
  output logic       dma_o
);
  logic [6:0] op;
  assign op    = code_i[6:0];
  assign dma_o = code_i[7];

  always_comb begin
    grp_o = GRP_BAD;
    act_o = ACT_NONE;
    case (op)
      7'h00: begin grp_o = GRP_ANY;  act_o = ACT_NONE;    end
      7'h01: begin grp_o = GRP_ANY;  act_o = ACT_FLUSH;   end
      7'h02: begin grp_o = GRP_ANY;  act_o = ACT_CHIPRST; end
      7'h03: begin grp_o = GRP_ANY;  act_o = ACT_BUSRST;  end
      7'h10: begin grp_o = GRP_CONN; act_o = ACT_XFER;    end
      7'h11: begin grp_o = GRP_CONN; act_o = ACT_ICCS;    end
      7'h12: begin grp_o = GRP_CONN; act_o = ACT_MSGOK;   end
      7'h18: begin grp_o = GRP_CONN; act_o = ACT_FDONE;   end
      7'h1a, 7'h1b: begin grp_o = GRP_CONN; act_o = ACT_NONE; end
      7'h40, 7'h47: begin grp_o = GRP_DISC; act_o = ACT_FDONE; end
      7'h41, 7'h42, 7'h43, 7'h46: begin grp_o = GRP_DISC; act_o = ACT_SELECT; end
      7'h44, 7'h45: begin grp_o = GRP_DISC; act_o = ACT_NONE; end
      default: begin grp_o = GRP_BAD; act_o = ACT_NONE; end
    endcase
  end
endmodule

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
  parameter  int DEPTH = 16,
  parameter  int W     = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout_o  = (cnt != '0) ? mem[rptr] : '0;
  assign count_o = cnt;

  // R11
  fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !flush_i && cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH)));

  // R2
  fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt == '0));
endmodule

// File: rtl/scsi_link_seq.sv
module scsi_link_seq
  import scsi_disp_pkg::*;
#(
  parameter  int SEL_DELAY = 4,
  localparam int TW        = $clog2(SEL_DELAY + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_stb_i,
  input  grp_e       grp_i,
  input  act_e       act_i,
  input  logic       dma_i,
  input  logic       rpt_dis_i,
  input  logic       intr_rd_i,
  output link_e      link_o,
  output logic [7:0] intr_o,
  output logic [2:0] step_o,
  output logic [2:0] phase_o,
  output logic       xdone_o,
  output logic       dma_mode_o,
  output logic       flush_o,
  output logic       cnt_load_o,
  output logic       cnt_clr_o
);
  link_e         link_q;
  logic [TW-1:0] tmr_q;
  logic [7:0]    intr_q, set_bits;
  logic [2:0]    step_q, phase_q;
  logic          xdone_q, dma_q;
  logic          legal, sel_done;
  act_e          act_go;

  always_comb begin
    legal = 1'b0;
    if (cmd_stb_i) begin
      case (grp_i)
        GRP_ANY:  legal = 1'b1;
        GRP_CONN: legal = (link_q == LNK_CONN);
        GRP_DISC: legal = (link_q == LNK_IDLE);
        default:  legal = 1'b0;
      endcase
    end
  end

  assign act_go   = legal ? act_i : ACT_NONE;
  assign sel_done = (link_q == LNK_SEL) && (tmr_q == '0);

  always_comb begin
    set_bits = '0;
    if (sel_done) set_bits[IB_FDONE] = 1'b1;
    if (cmd_stb_i && !legal) set_bits[IB_ILL] = 1'b1;
    case (act_go)
      ACT_BUSRST:          if (!rpt_dis_i) set_bits[IB_BRST] = 1'b1;
      ACT_XFER:            set_bits[IB_BSERV] = 1'b1;
      ACT_ICCS, ACT_FDONE: set_bits[IB_FDONE] = 1'b1;
      ACT_MSGOK:           set_bits[IB_DISC]  = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || act_go == ACT_CHIPRST) begin
      link_q  <= LNK_IDLE;
      tmr_q   <= '0;
      intr_q  <= '0;
      step_q  <= '0;
      phase_q <= PH_IDLE;
      xdone_q <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      intr_q  <= (intr_rd_i ? 8'h00 : intr_q) | set_bits;
      step_q  <= sel_done ? STEP_SENT : (intr_rd_i ? 3'd0 : step_q);
      xdone_q <= (act_go == ACT_XFER) ? 1'b1 : (intr_rd_i ? 1'b0 : xdone_q);
      if (legal) dma_q <= dma_i;
      case (act_go)
        ACT_BUSRST, ACT_MSGOK: begin
          link_q  <= LNK_IDLE;
          phase_q <= PH_IDLE;
        end
        ACT_SELECT: begin
          link_q <= LNK_SEL;
          tmr_q  <= TW'(SEL_DELAY - 1);
        end
        ACT_XFER: phase_q <= (phase_q == PH_CMD) ? PH_STAT : PH_MIN;
        ACT_ICCS: phase_q <= PH_MIN;
        default: begin
          if (sel_done) begin
            link_q  <= LNK_CONN;
            phase_q <= PH_CMD;
          end else if (link_q == LNK_SEL) begin
            tmr_q <= tmr_q - TW'(1);
          end
        end
      endcase
    end
  end

  assign link_o     = link_q;
  assign intr_o     = intr_q;
  assign step_o     = step_q;
  assign phase_o    = phase_q;
  assign xdone_o    = xdone_q;
  assign dma_mode_o = dma_q;
  assign flush_o    = (act_go == ACT_FLUSH) || (act_go == ACT_CHIPRST);
  assign cnt_load_o = legal && dma_i && (act_go != ACT_CHIPRST);
  assign cnt_clr_o  = (act_go == ACT_CHIPRST);

  // R8
  no_idle_to_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q == LNK_IDLE) |=> (link_q != LNK_CONN));

  // R5
  illegal_keeps_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb_i && !legal && link_q != LNK_SEL) |=> ($stable(link_q) && intr_q[IB_ILL]));

  // R10
  intr_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_rd_i && set_bits == 8'h00) |=> (intr_q == 8'h00));
endmodule

// File: rtl/scsi_cmd_dispatch.sv
module scsi_cmd_dispatch
  import scsi_disp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int SEL_DELAY  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       link_up,
  output logic       dma_mode
);
  localparam int FCW = $clog2(FIFO_DEPTH) + 1;
  localparam int XW  = 16;

  logic [7:0]    cnt_lo, cnt_mid, cmd_q, cfg_q;
  logic [XW-1:0] xcnt;
  logic          cmd_stb, intr_rd, fifo_push, fifo_pop;
  grp_e          grp;
  act_e          act;
  logic          dma_bit;
  link_e         link;
  logic [7:0]    intr, fifo_dout, status, flags;
  logic [2:0]    step, phase;
  logic          xdone, flush, cnt_load, cnt_clr;
  logic [FCW-1:0] fcount;

  assign cmd_stb   = reg_wr && (reg_addr == SLOT_CMD);
  assign intr_rd   = reg_rd && (reg_addr == SLOT_INTR);
  assign fifo_push = reg_wr && (reg_addr == SLOT_FIFO);
  assign fifo_pop  = reg_rd && (reg_addr == SLOT_FIFO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lo  <= '0;
      cnt_mid <= '0;
      cmd_q   <= '0;
      cfg_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        SLOT_CNT_LO:  cnt_lo  <= reg_wdata;
        SLOT_CNT_MID: cnt_mid <= reg_wdata;
        SLOT_CMD:     cmd_q   <= reg_wdata;
        SLOT_CFG:     cfg_q   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_clr) xcnt <= '0;
    else if (cnt_load)     xcnt <= {cnt_mid, cnt_lo};
  end

  scsi_cmd_decode u_dec (
    .code_i (reg_wdata),
    .grp_o  (grp),
    .act_o  (act),
    .dma_o  (dma_bit)
  );

  scsi_link_seq #(.SEL_DELAY(SEL_DELAY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_stb_i  (cmd_stb),
    .grp_i      (grp),
    .act_i      (act),
    .dma_i      (dma_bit),
    .rpt_dis_i  (cfg_q[CFG_RPT_DIS]),
    .intr_rd_i  (intr_rd),
    .link_o     (link),
    .intr_o     (intr),
    .step_o     (step),
    .phase_o    (phase),
    .xdone_o    (xdone),
    .dma_mode_o (dma_mode),
    .flush_o    (flush),
    .cnt_load_o (cnt_load),
    .cnt_clr_o  (cnt_clr)
  );

  scsi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (fifo_push),
    .pop_i   (fifo_pop),
    .flush_i (flush),
    .din_i   (reg_wdata),
    .dout_o  (fifo_dout),
    .count_o (fcount)
  );

  assign irq     = |intr;
  assign link_up = (link == LNK_CONN);
  assign status  = {irq, 1'b0, 1'b0, (xcnt == '0), xdone, phase};
  assign flags   = {step, 5'(fcount)};

  always_comb begin
    case (reg_addr)
      SLOT_CNT_LO:  reg_rdata = cnt_lo;
      SLOT_CNT_MID: reg_rdata = cnt_mid;
      SLOT_FIFO:    reg_rdata = fifo_dout;
      SLOT_CMD:     reg_rdata = cmd_q;
      SLOT_STAT:    reg_rdata = status;
      SLOT_INTR:    reg_rdata = intr;
      SLOT_STEP:    reg_rdata = {5'd0, step};
      SLOT_FFLAG:   reg_rdata = flags;
      SLOT_CFG:     reg_rdata = cfg_q;
      default:      reg_rdata = 8'h00;
    endcase
  end

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (xcnt == $past({cnt_mid, cnt_lo})));
endmodule

// File: tb/scsi_cmd_dispatch_tb.sv
module scsi_cmd_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_DELAY  = 4;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, link_up, dma_mode;

  scsi_cmd_dispatch #(.FIFO_DEPTH(DEPTH), .SEL_DELAY(SEL_DELAY)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .link_up(link_up),
    .dma_mode(dma_mode)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_run = 0, n_fail = 0;

  // reference model: link 0 idle, 1 selecting, 2 connected
  int         m_link = 0, m_tmr = 0, m_step = 0, m_phase = 0, m_xcnt = 0;
  logic [7:0] m_intr = 0, m_lo = 0, m_mid = 0, m_cmd = 0, m_cfg = 0;
  bit         m_xdone = 0, m_dma = 0;
  byte unsigned m_q[$];

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int grp_of(logic [6:0] op);
    if (op <= 7'h03) return 0;
    if (op == 7'h10 || op == 7'h11 || op == 7'h12 || op == 7'h18 || op == 7'h1a || op == 7'h1b)
      return 1;
    if (op >= 7'h40 && op <= 7'h47) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] m_read(int a);
    case (a)
      0: return m_lo;
      1: return m_mid;
      2: return (m_q.size() > 0) ? m_q[0] : 8'h00;
      3: return m_cmd;
      4: return {(m_intr != 0), 2'b00, (m_xcnt == 0), m_xdone, 3'(m_phase)};
      5: return m_intr;
      6: return 8'(m_step);
      7: return {3'(m_step), 5'(m_q.size())};
      8: return m_cfg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_step_model(bit wr, bit rd, int a, logic [7:0] d);
    logic [7:0] s;
    int nlink, ntmr, nphase, g;
    bit seldone, legal, chiprst, xfer, intr_rd;
    s = 0; nlink = m_link; ntmr = m_tmr; nphase = m_phase;
    chiprst = 0; xfer = 0;
    seldone = (m_link == 1 && m_tmr == 0);
    if (m_link == 1) begin
      if (m_tmr == 0) begin nlink = 2; nphase = 2; s |= 8'h08; end
      else ntmr = m_tmr - 1;
    end
    if (wr) begin
      case (a)
        0: m_lo = d;
        1: m_mid = d;
        2: if (m_q.size() < DEPTH) m_q.push_back(d);
        3: begin
          m_cmd = d;
          g = grp_of(d[6:0]);
          legal = (g == 0) || (g == 1 && m_link == 2) || (g == 2 && m_link == 0);
          if (!legal) s |= 8'h40;
          else begin
            m_dma = d[7];
            if (d[7]) m_xcnt = {m_mid, m_lo};
            case (d[6:0])
              7'h01: m_q.delete();
              7'h02: chiprst = 1;
              7'h03: begin nlink = 0; nphase = 0; if (!m_cfg[6]) s |= 8'h80; end
              7'h10: begin nphase = (m_phase == 2) ? 3 : 7; s |= 8'h10; xfer = 1; end
              7'h11: begin nphase = 7; s |= 8'h08; end
              7'h12: begin nlink = 0; nphase = 0; s |= 8'h20; end
              7'h18, 7'h40, 7'h47: s |= 8'h08;
              7'h41, 7'h42, 7'h43, 7'h46: begin nlink = 1; ntmr = SEL_DELAY - 1; end
              default: ;
            endcase
          end
        end
        8: m_cfg = d;
        default: ;
      endcase
    end
    if (rd && a == 2 && m_q.size() > 0) void'(m_q.pop_front());
    intr_rd = rd && (a == 5);
    m_intr  = (intr_rd ? 8'h00 : m_intr) | s;
    m_step  = seldone ? 4 : (intr_rd ? 0 : m_step);
    m_xdone = xfer ? 1'b1 : (intr_rd ? 1'b0 : m_xdone);
    m_link = nlink; m_tmr = ntmr; m_phase = nphase;
    if (chiprst) begin
      m_link = 0; m_tmr = 0; m_intr = 0; m_step = 0; m_phase = 0;
      m_xdone = 0; m_dma = 0; m_xcnt = 0; m_q.delete();
    end
  endtask

  task automatic cyc(bit wr, bit rd, int a, logic [7:0] d, string tag);
    @(negedge clk);
    chk("R10 irq pin", int'(irq), int'(m_intr != 0));
    chk("R8 link_up pin", int'(link_up), int'(m_link == 2));
    chk("R7 dma_mode pin", int'(dma_mode), int'(m_dma));
    reg_wr = wr; reg_rd = rd; reg_addr = 4'(a); reg_wdata = d;
    #1;
    if (rd) chk(tag, int'(reg_rdata), int'(m_read(a)));
    @(posedge clk);
    m_step_model(wr, rd, a, d);
    #1;
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wr(int a, logic [7:0] d); cyc(1, 0, a, d, ""); endtask
  task automatic rd(int a, string tag); cyc(0, 1, a, 8'h00, tag); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, ""); endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 R12 reset values of every slot
    for (int a = 0; a < 16; a++) rd(a, "R1 R12 reset read");
    // R1 read/write slots and write-only aliases
    wr(0, 8'h34); wr(1, 8'h12); wr(8, 8'h07);
    rd(0, "R1 count low"); rd(1, "R1 count mid"); rd(8, "R1 config");
    for (int a = 4; a < 8; a++) wr(a, 8'hFF);
    for (int a = 4; a < 8; a++) rd(a, "R1 write-only alias");
    // R5 group 2 while idle, undefined code
    wr(3, 8'h10); rd(5, "R5 illegal group2 idle"); rd(5, "R10 read cleared");
    wr(3, 8'h20); rd(3, "R1 command readback"); rd(5, "R5 undefined code");
    // R7 DMA nop loads counter; illegal DMA command changes nothing
    wr(3, 8'h80); rd(4, "R7 counter loaded");
    wr(0, 8'h00); wr(1, 8'h00);
    wr(3, 8'h90); rd(4, "R7 illegal keeps counter"); rd(5, "R5 illegal with dma bit");
    // R6 group 4 while idle
    wr(3, 8'h44); rd(5, "R6 enable select quiet");
    wr(3, 8'h40); rd(5, "R6 reselect done");
    // R8 selection with a command during selecting
    wr(3, 8'hC2); wr(3, 8'h41); wr(3, 8'h10);
    idle(SEL_DELAY);
    rd(6, "R8 step four"); rd(7, "R11 flags carry step"); rd(4, "R8 R12 command phase");
    rd(5, "R8 R10 function done"); rd(6, "R10 step cleared");
    // R6 select while connected; R9 connected actions
    wr(3, 8'h41); rd(5, "R6 select while connected");
    wr(3, 8'h10); rd(4, "R9 status phase"); rd(5, "R9 bus service");
    rd(4, "R10 xfer flag cleared");
    wr(3, 8'h10); rd(4, "R9 message in phase");
    wr(3, 8'h1a); wr(3, 8'h18); rd(5, "R9 pad done");
    wr(3, 8'h11); rd(5, "R9 complete sequence");
    wr(3, 8'h12); rd(4, "R9 disconnect phase"); rd(5, "R9 disconnect intr");
    // R11 FIFO fill, overflow, drain, underflow
    for (int i = 0; i < 17; i++) wr(2, 8'(8'hA0 + i));
    rd(7, "R11 full count");
    for (int i = 0; i < 17; i++) rd(2, "R11 fifo data");
    rd(7, "R11 empty count");
    // R2 flush
    for (int i = 0; i < 3; i++) wr(2, 8'(i + 1));
    rd(7, "R11 three bytes"); wr(3, 8'h01); rd(7, "R2 flushed"); rd(2, "R2 empty read");
    // R4 bus reset reported and masked
    wr(3, 8'h03); rd(5, "R4 reset reported");
    wr(8, 8'h47); wr(3, 8'h03); rd(5, "R4 reset masked");
    wr(3, 8'h42); idle(SEL_DELAY + 1); rd(5, "R8 connect again");
    wr(3, 8'h03); rd(4, "R4 disconnected by bus reset"); rd(5, "R4 masked while connected");
    // R10 interrupt reads across the completion edge
    wr(8, 8'h07); wr(3, 8'h42);
    for (int i = 0; i < SEL_DELAY + 2; i++) rd(5, "R10 read near completion");
    rd(6, "R10 step after reads");
    // R3 chip reset from connected with a loaded counter
    wr(0, 8'h05); wr(3, 8'h80); wr(2, 8'h55); wr(3, 8'h10);
    wr(3, 8'h02);
    rd(4, "R3 status after chip reset"); rd(5, "R3 intr after chip reset");
    rd(7, "R3 fifo after chip reset"); rd(0, "R3 count kept"); rd(8, "R3 config kept");
    wr(3, 8'h41); idle(SEL_DELAY + 1); rd(5, "R3 R6 idle after chip reset");
    idle(2);
    summary();
    $finish;
  end
endmodule